// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Warning

This block supervises software liveness. Once armed, it counts cycles of a watchdog tick enable. Software must restart the count by writing a fixed key to a restart register before the programmed time-out expires. If the count reaches the time-out, or software writes a wrong key, the block raises a one-cycle system-reset request. A windowed variant also treats a restart that comes too soon as a fault, so a runaway loop that restarts the count constantly is still caught.

Three 4-bit length codes set the time-out, the closed window and the early-warning lead. Each code n selects 8 << n ticks; codes above 0xB behave as 0xB. A sticky warning flag is raised a programmable number of ticks before the time-out. When its enable is set, the flag drives an interrupt line. A lock bit freezes the arming and timing fields until the next reset. A status bit models the busy time of a write that, in a real chip, would cross into the watchdog clock domain. The register port is byte wide with a 4-bit address. A write takes effect at the clock edge where `wr_en_i` is high, and read data is a combinational function of `addr_i`.

Top module: `wwd_top`

## Requirements
- R1: After reset, the registers read as follows: 0x0 reads 0x00, 0x1 reads 0xBB, 0x2 reads 0x0B, and 0x4, 0x5, 0x6 and 0x7 all read 0x00. `rst_req_o` and `irq_o` are low.
- R2: In the control register at 0x0, only bit 1 (arm), bit 2 (window mode) and bit 7 (lock) can be written, and all other bits read 0. Address 0x3, address 0x8 and unmapped addresses read 0x00.
- R3: The time-out T is 8 << code, where the code is bits 3:0 of 0x1. The count advances only at edges where `tick_i` is high. When T ticks have been counted since arming or since the last accepted restart, `rst_req_o` is high for one cycle and counting restarts from zero. While disarmed, the count stays at zero.
- R4: While armed, writing 0xA5 to 0x8 restarts the count from zero. If that write coincides with the time-out tick, the restart wins and no reset request is raised.
- R5: While armed, a write of any value other than 0xA5 to 0x8 raises `rst_req_o` for exactly the cycle after the write. While disarmed, writes to 0x8 have no effect.
- R6: In window mode, the closed window W is 8 << code, where the code is bits 7:4 of 0x1. A 0xA5 restart issued while fewer than W ticks have been counted raises the reset request. A restart issued once W or more ticks have been counted is accepted.
- R7: When the early-warning lead E is smaller than T, the warning flag (bit 0 of 0x6) is set at the edge where the count reaches T−E. E is 8 << code, where the code is bits 3:0 of 0x2. The flag stays set until 1 is written to bit 0 of 0x6. Writing 0 there has no effect. A clear that coincides with a new warning leaves the flag set.
- R8: The interrupt enable is bit 0. Writing 1 there at 0x5 sets it, writing 1 there at 0x4 clears it, writing 0 at either address has no effect, and both addresses read it back. `irq_o` is the warning flag gated by this enable.
- R9: Bit 7 of 0x7 reads 1 for BUSY_CYC cycles after a write to 0x0, 0x1 or 0x8, and 0 otherwise.
- R10: Once bit 7 of 0x0 has been written as 1, the register at 0x0 and the register at 0x1 ignore all writes until reset. The register at 0x2 stays writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Watchdog tick enable; the count advances on it |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| rst_req_o | output | 1 | One-cycle system-reset request |
| irq_o | output | 1 | Early-warning interrupt |

## Verification
Two pairs of events can fall on the same edge, and each pair is provoked on purpose. The first pair is a 0xA5 restart written in the cycle where the count sits one tick short of the time-out. There the bench expects the reset request to stay low, and it expects the next time-out a full period later. The second pair is a write of 1 to the warning-flag clear, placed on the edge where the next period's warning fires. There the bench reads the flag back and expects it to still be 1. The window boundary is judged on both sides: a restart at one tick under W must fault, and a restart at exactly W must be accepted.

// File: rtl/wwd_pkg.sv
package wwd_pkg;
  localparam int unsigned AW = 4;
  localparam int unsigned DW = 8;

  localparam logic [AW-1:0] A_CTL    = 4'h0;
  localparam logic [AW-1:0] A_CFG    = 4'h1;
  localparam logic [AW-1:0] A_WARN   = 4'h2;
  localparam logic [AW-1:0] A_IE_CLR = 4'h4;
  localparam logic [AW-1:0] A_IE_SET = 4'h5;
  localparam logic [AW-1:0] A_FLAG   = 4'h6;
  localparam logic [AW-1:0] A_STAT   = 4'h7;
  localparam logic [AW-1:0] A_KICK   = 4'h8;

  localparam logic [DW-1:0] KICK_KEY = 8'hA5;
  localparam logic [DW-1:0] CFG_RST  = 8'hBB;
  localparam logic [3:0]    WARN_RST = 4'hB;

  localparam int unsigned BIT_ARM  = 1;
  localparam int unsigned BIT_WIN  = 2;
  localparam int unsigned BIT_LOCK = 7;

  typedef struct packed {
    logic lock;
    logic win;
    logic arm;
  } ctl_t;
endpackage

// File: rtl/wwd_span.sv
module wwd_span #(
  parameter int unsigned BASE_LOG = 3,
  parameter int unsigned CODE_MAX = 11,
  parameter int unsigned CW       = BASE_LOG + CODE_MAX + 1
) (
  input  logic [3:0]    code_i,
  output logic [CW-1:0] cyc_o
);
  logic [3:0] eff;
  // codes above the top value saturate
  assign eff   = (code_i > 4'(CODE_MAX)) ? 4'(CODE_MAX) : code_i;
  assign cyc_o = CW'(1) << (BASE_LOG + 32'(eff));
endmodule

// File: rtl/wwd_core.sv
module wwd_core #(
  parameter int unsigned CW = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          arm_i,
  input  logic          win_i,
  input  logic [CW-1:0] per_cyc_i,
  input  logic [CW-1:0] win_cyc_i,
  input  logic [CW-1:0] warn_cyc_i,
  input  logic          kick_wr_i,
  input  logic          kick_ok_i,
  output logic          warn_hit_o,
  output logic          rst_req_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          fault;
  logic          last_tick;
  logic          early;

  assign last_tick = (cnt_q >= per_cyc_i - CW'(1));
  assign early     = win_i && (cnt_q < win_cyc_i);

  always_comb begin
    cnt_d = cnt_q;
    fault = 1'b0;
    if (!arm_i) begin
      cnt_d = '0;
    end else if (kick_wr_i) begin
      cnt_d = '0;
      fault = !kick_ok_i || early;
    end else if (tick_i) begin
      if (last_tick) begin
        cnt_d = '0;
        fault = 1'b1;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  assign warn_hit_o = arm_i && !kick_wr_i && tick_i && !last_tick &&
                      (warn_cyc_i < per_cyc_i) &&
                      ((cnt_q + CW'(1)) == (per_cyc_i - warn_cyc_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      rst_req_o <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      rst_req_o <= fault;
    end
  end

  AST_IDLE_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> (cnt_q == '0));  // R3
  AST_IDLE_NO_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> !rst_req_o);  // R5
  AST_EARLY_KICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && win_i && kick_wr_i && (cnt_q < win_cyc_i)) |=> rst_req_o);  // R6
  AST_GOOD_KICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && !win_i && kick_wr_i && kick_ok_i) |=> (!rst_req_o && cnt_q == '0));  // R4
endmodule

// File: rtl/wwd_regs.sv
module wwd_regs
  import wwd_pkg::*;
#(
  parameter int unsigned BUSY_CYC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          warn_hit_i,
  output ctl_t          ctl_o,
  output logic [3:0]    per_code_o,
  output logic [3:0]    win_code_o,
  output logic [3:0]    warn_code_o,
  output logic          kick_wr_o,
  output logic          kick_ok_o,
  output logic          irq_o
);
  localparam int unsigned BCW = $clog2(BUSY_CYC + 1);

  ctl_t          ctl_q;
  logic [DW-1:0] cfg_q;
  logic [3:0]    warn_q;
  logic          ie_q, flag_q;
  logic [BCW-1:0] busy_q;
  logic          busy;
  logic          sync_wr;

  assign sync_wr = wr_en_i && (addr_i == A_CTL || addr_i == A_CFG || addr_i == A_KICK);
  assign busy    = (busy_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      cfg_q  <= CFG_RST;
      warn_q <= WARN_RST;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
      busy_q <= '0;
    end else begin
      if (wr_en_i && !ctl_q.lock) begin
        if (addr_i == A_CTL) begin
          ctl_q.arm  <= wdata_i[BIT_ARM];
          ctl_q.win  <= wdata_i[BIT_WIN];
          ctl_q.lock <= wdata_i[BIT_LOCK];
        end
        if (addr_i == A_CFG) cfg_q <= wdata_i;
      end
      if (wr_en_i && addr_i == A_WARN) warn_q <= wdata_i[3:0];
      if (wr_en_i && addr_i == A_IE_CLR && wdata_i[0]) ie_q <= 1'b0;
      if (wr_en_i && addr_i == A_IE_SET && wdata_i[0]) ie_q <= 1'b1;
      // a new warning outranks a coincident clear
      if (warn_hit_i) flag_q <= 1'b1;
      else if (wr_en_i && addr_i == A_FLAG && wdata_i[0]) flag_q <= 1'b0;
      if (sync_wr) busy_q <= BCW'(BUSY_CYC);
      else if (busy) busy_q <= busy_q - BCW'(1);
    end
  end

  always_comb begin
    unique case (addr_i)
      A_CTL:              rdata_o = {ctl_q.lock, 4'b0, ctl_q.win, ctl_q.arm, 1'b0};
      A_CFG:              rdata_o = cfg_q;
      A_WARN:             rdata_o = {4'b0, warn_q};
      A_IE_CLR, A_IE_SET: rdata_o = {7'b0, ie_q};
      A_FLAG:             rdata_o = {7'b0, flag_q};
      A_STAT:             rdata_o = {busy, 7'b0};
      default:            rdata_o = '0;
    endcase
  end

  assign ctl_o       = ctl_q;
  assign per_code_o  = cfg_q[3:0];
  assign win_code_o  = cfg_q[7:4];
  assign warn_code_o = warn_q;
  assign kick_wr_o   = wr_en_i && (addr_i == A_KICK);
  assign kick_ok_o   = (wdata_i == KICK_KEY);
  assign irq_o       = flag_q && ie_q;

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !(wr_en_i && addr_i == A_FLAG && wdata_i[0])) |=> flag_q);  // R7
  AST_WARN_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warn_hit_i |=> flag_q);  // R7
  AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_q.lock |=> (ctl_q.lock && $stable(cfg_q) && $stable(ctl_q)));  // R10
  AST_BUSY_AFTER_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_wr |=> busy);  // R9
endmodule

// File: rtl/wwd_top.sv
module wwd_top
  import wwd_pkg::*;
#(
  parameter int unsigned BASE_LOG = 3,
  parameter int unsigned CODE_MAX = 11,
  parameter int unsigned BUSY_CYC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rst_req_o,
  output logic          irq_o
);
  localparam int unsigned CW = BASE_LOG + CODE_MAX + 1;
  localparam int unsigned NSPAN = 3;

  ctl_t          ctl;
  logic [3:0]    codes [NSPAN];
  logic [CW-1:0] spans [NSPAN];
  logic          kick_wr, kick_ok, warn_hit;

  wwd_regs #(.BUSY_CYC(BUSY_CYC)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .rdata_o     (rdata_o),
    .warn_hit_i  (warn_hit),
    .ctl_o       (ctl),
    .per_code_o  (codes[0]),
    .win_code_o  (codes[1]),
    .warn_code_o (codes[2]),
    .kick_wr_o   (kick_wr),
    .kick_ok_o   (kick_ok),
    .irq_o       (irq_o)
  );

  for (genvar g = 0; g < NSPAN; g++) begin : g_span
    wwd_span #(.BASE_LOG(BASE_LOG), .CODE_MAX(CODE_MAX), .CW(CW)) u_span (
      .code_i (codes[g]),
      .cyc_o  (spans[g])
    );
  end

  wwd_core #(.CW(CW)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .arm_i      (ctl.arm),
    .win_i      (ctl.win),
    .per_cyc_i  (spans[0]),
    .win_cyc_i  (spans[1]),
    .warn_cyc_i (spans[2]),
    .kick_wr_i  (kick_wr),
    .kick_ok_i  (kick_ok),
    .warn_hit_o (warn_hit),
    .rst_req_o  (rst_req_o)
  );
endmodule

// File: tb/sim_wwd_top.sv
`timescale 1ns/1ps
module sim_wwd_top;
  localparam int SIG_RST = 0, SIG_IRQ = 1, SIG_RD = 2;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick = 1'b1;
  logic       wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rst_req, irq;

  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct {
    int         at;
    int         sig;
    logic [7:0] val;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wwd_top u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .rst_req_o(rst_req), .irq_o(irq)
  );

  // monitor: compare every item due in this cycle
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].at == cyc) begin
        logic [7:0] act;
        case (sb[i].sig)
          SIG_RST: act = {7'b0, rst_req};
          SIG_IRQ: act = {7'b0, irq};
          default: act = rdata;
        endcase
        n_run++;
        if (act !== sb[i].val) begin
          n_fail++;
          $display("FAIL %s cyc=%0d sig=%0d actual=%02h expected=%02h",
                   sb[i].tag, cyc, sb[i].sig, act, sb[i].val);
        end
        sb.delete(i);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic expect_at(input int d, input int sig, input logic [7:0] v, input string tag);
    exp_t e;
    e.at = cyc + d; e.sig = sig; e.val = v; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    step(1);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] v, input string tag);
    addr = a;
    expect_at(0, SIG_RD, v, tag);
    step(1);
  endtask

  task automatic finish_run();
    foreach (sb[i]) begin
      n_run++; n_fail++;
      $display("FAIL %s never checked actual=none expected=%02h", sb[i].tag, sb[i].val);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    step(3);
    rst_ni = 1'b1;
    step(1);

    // R1 reset state
    expect_at(0, SIG_RST, 0, "R1 rst_req");
    expect_at(0, SIG_IRQ, 0, "R1 irq");
    rd(4'h0, 8'h00, "R1 ctl");
    rd(4'h1, 8'hBB, "R1 cfg");
    rd(4'h2, 8'h0B, "R1 warn");
    rd(4'h4, 8'h00, "R1 ie");
    rd(4'h6, 8'h00, "R1 flag");
    rd(4'h7, 8'h00, "R1 status");

    // R2 masks and unmapped reads
    wr(4'h0, 8'h79);
    rd(4'h0, 8'h00, "R2 ctl mask");
    wr(4'h3, 8'hFF);
    rd(4'h3, 8'h00, "R2 gap addr");
    rd(4'h8, 8'h00, "R2 kick reads zero");
    step(3);

    // R9 busy window after a config write
    wr(4'h1, 8'h02);
    rd(4'h7, 8'h80, "R9 busy 1st");
    rd(4'h7, 8'h80, "R9 busy 2nd");
    rd(4'h7, 8'h00, "R9 busy done");

    // R8 interrupt enable set/clear
    wr(4'h5, 8'h01);
    rd(4'h4, 8'h01, "R8 ie via clr addr");
    rd(4'h5, 8'h01, "R8 ie via set addr");
    wr(4'h4, 8'h00);
    rd(4'h4, 8'h01, "R8 zero ignored");
    wr(4'h4, 8'h01);
    rd(4'h5, 8'h00, "R8 ie cleared");
    wr(4'h5, 8'h01);

    // R3/R7: T=32, E=16
    wr(4'h2, 8'h01);
    wr(4'h0, 8'h02);
    expect_at(15, SIG_IRQ, 0, "R7 before warning");
    expect_at(16, SIG_IRQ, 1, "R7 warning");
    expect_at(31, SIG_RST, 0, "R3 before timeout");
    expect_at(32, SIG_RST, 1, "R3 timeout");
    expect_at(33, SIG_RST, 0, "R3 one-cycle pulse");
    step(20);
    wr(4'h6, 8'h00);
    rd(4'h6, 8'h01, "R7 write 0 ignored");
    step(12);
    wr(4'h6, 8'h01);
    expect_at(0, SIG_IRQ, 0, "R7 flag clear irq");
    rd(4'h6, 8'h00, "R7 flag cleared");
    step(11);
    wr(4'h6, 8'h01);           // same edge as second warning
    rd(4'h6, 8'h01, "R7 set beats clear");
    wr(4'h0, 8'h00);
    wr(4'h4, 8'h01);
    expect_at(0, SIG_IRQ, 0, "R8 irq gated");
    step(1);
    wr(4'h5, 8'h01);
    expect_at(0, SIG_IRQ, 1, "R8 irq enabled");
    step(1);
    wr(4'h6, 8'h01);
    step(3);

    // R4 keyed restart and restart/timeout collision
    wr(4'h0, 8'h02);
    step(19);
    wr(4'h8, 8'hA5);
    expect_at(12, SIG_RST, 0, "R4 old deadline passed");
    expect_at(31, SIG_RST, 0, "R4 before new deadline");
    expect_at(32, SIG_RST, 1, "R4 new deadline");
    step(63);
    wr(4'h8, 8'hA5);
    expect_at(0, SIG_RST, 0, "R4 restart beats timeout");
    expect_at(1, SIG_RST, 0, "R4 restart beats timeout +1");
    expect_at(32, SIG_RST, 1, "R4 timeout after collision");
    step(33);

    // R5 wrong key, then disarmed
    wr(4'h8, 8'h5A);
    expect_at(0, SIG_RST, 1, "R5 wrong key");
    expect_at(1, SIG_RST, 0, "R5 wrong key pulse");
    step(2);
    wr(4'h0, 8'h00);
    wr(4'h8, 8'h5A);
    expect_at(0, SIG_RST, 0, "R5 ignored disarmed");
    step(2);

    // R6 window: T=64, W=16
    wr(4'h1, 8'h13);
    wr(4'h0, 8'h06);
    step(15);
    wr(4'h8, 8'hA5);
    expect_at(0, SIG_RST, 1, "R6 early restart");
    step(16);
    wr(4'h8, 8'hA5);
    expect_at(0, SIG_RST, 0, "R6 restart at W");
    expect_at(63, SIG_RST, 0, "R6 before timeout");
    expect_at(64, SIG_RST, 1, "R6 timeout after accepted");
    step(65);
    wr(4'h0, 8'h00);

    // R3 tick gating: T=8
    wr(4'h1, 8'h00);
    tick = 1'b0;
    wr(4'h0, 8'h02);
    expect_at(8, SIG_RST, 0, "R3 no tick no count");
    expect_at(20, SIG_RST, 0, "R3 no tick no count late");
    step(20);
    tick = 1'b1;
    expect_at(7, SIG_RST, 0, "R3 ticks before timeout");
    expect_at(8, SIG_RST, 1, "R3 ticks timeout");
    step(10);
    wr(4'h0, 8'h00);

    // R10 lock
    wr(4'h1, 8'h03);
    wr(4'h0, 8'h82);
    rd(4'h0, 8'h82, "R10 locked ctl");
    wr(4'h0, 8'h00);
    rd(4'h0, 8'h82, "R10 ctl frozen");
    wr(4'h1, 8'h00);
    rd(4'h1, 8'h03, "R10 cfg frozen");
    wr(4'h2, 8'h05);
    rd(4'h2, 8'h05, "R10 warn writable");
    rst_ni = 1'b0;
    step(2);
    rst_ni = 1'b1;
    step(1);
    rd(4'h0, 8'h00, "R10 reset unlocks");
    rd(4'h1, 8'hBB, "R10 reset cfg");
    step(2);

    done = 1;
    finish_run();
  end
endmodule